// File: doc/BRIEF.md
# Trigger-Started ADC Conversion Controller

This block times the conversions of an analog-to-digital converter that samples only when an external start pulse asks it to. Two start inputs are merged by a logical OR, carried into the converter clock domain through a flop chain, and a low-to-high transition of the merged signal sets the sampling instant. A conversion then runs for a fixed number of converter-clock cycles. The digitization itself is modelled by this latency counter. A short settling gap follows each conversion. The busy level is carried back to the interface clock, and a one-cycle end-of-conversion strobe is raised a fixed number of interface cycles after busy falls. That strobe is the moment a result would be placed in the output register.

A sequence tracker in the interface domain walks a 16-bit channel-enable mask in ascending order and counts averaging passes. The end-of-sequence strobe fires together with the end-of-conversion strobe only for the last enabled channel of the final pass. Every start edge yields exactly one conversion, so a full sequence takes the number of enabled channels times the pass count edges.

The converter-domain machine has three states. CIDLE goes to CCONV on a start edge. CCONV goes to CSETTLE when the latency count expires. CSETTLE returns to CIDLE at the end of the gap, or goes straight back to CCONV if an edge was seen during the gap or at its last cycle. The interface-domain machine has two states. HIDLE goes to HWAIT when the synchronized busy falls, and HWAIT returns to HIDLE as the end-of-conversion strobe is issued. In the bench both clocks come from one source, so all cycle counts below hold exactly. In the requirements, edge E0 is the first rising clock edge at which a start input is already high.

Top module: `adc_evt_ctrl`

## Requirements
- R1: A rising edge of (trig_a OR trig_b) starts exactly one conversion, whichever input carries it. A rise on one input while the other is already high is no edge and starts nothing.
- R2: With the default parameters (latency 26, two synchronizer stages), busy is high from just after edge E4 until just after edge E30, that is 26 cycles.
- R3: A start edge that reaches the converter domain while a conversion is running is ignored. No second busy period and no second end-of-conversion strobe follow it.
- R4: A start edge that arrives during the 4-cycle settling gap after a conversion is held. The next conversion begins when the gap ends. For a first conversion started at E0 and a second start input rise just before edge E28, busy rises again just after edge E34.
- R5: eoc is high for exactly one interface cycle. It rises 16 interface edges after the edge at which busy falls, which is just after edge E46 for a conversion started at E0.
- R6: chan gives the channel of the next conversion. It moves to the next higher enabled bit of ch_mask on the same edge that eoc rises, and wraps to the lowest enabled bit past the highest. An all-zero mask acts as channel 0 alone.
- R7: eos is high only together with eoc, on the conversion of the highest enabled channel in the final pass. avg_sel selects the pass count: 00 gives 1 pass, 01 gives 16, 10 gives 64 and 11 gives 256.
- R8: A synchronous reset clears busy, eoc, eos, the pass count and the channel index (chan = 0). A start input held high through the release of reset starts no conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| conv_clk | input | 1 | Converter clock |
| if_clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| trig_a | input | 1 | Start input A, may be asynchronous |
| trig_b | input | 1 | Start input B, may be asynchronous |
| ch_mask | input | NUM_CH | Channel-enable mask |
| avg_sel | input | 2 | Averaging pass select |
| busy | output | 1 | Conversion in progress, interface domain |
| eoc | output | 1 | End-of-conversion strobe |
| eos | output | 1 | End-of-sequence strobe |
| chan | output | CH_W | Channel index of the next conversion |

## Verification
The hardest case to reach from the ports is a start edge that lands inside the four-cycle settling gap. That gap is not visible at the busy output, which only shows the converter state two cycles late. The bench reaches it by counting clock edges from a known first start. It drops the start input early, then raises it again just before edge E28, so the synchronized edge reaches the converter while it is settling. The only evidence of the held edge is a second busy period that begins exactly at E34. Reaching the 256-pass end of sequence likewise needs long back-to-back trains of start pulses, each fired just after the previous strobe.

// File: rtl/adc_evt_pkg.sv
`timescale 1ns/1ps
package adc_evt_pkg;

    typedef enum logic [1:0] {
        CIDLE   = 2'd0,
        CCONV   = 2'd1,
        CSETTLE = 2'd2
    } conv_state_t;

    typedef enum logic {
        HIDLE = 1'b0,
        HWAIT = 1'b1
    } hand_state_t;

    localparam int PASS_W = 9;

    function automatic logic [PASS_W-1:0] avg_passes(input logic [1:0] sel);
        logic [PASS_W-1:0] n;
        unique case (sel)
            2'b00: n = PASS_W'(1);
            2'b01: n = PASS_W'(16);
            2'b10: n = PASS_W'(64);
            default: n = PASS_W'(256);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adc_evt_trig.sv
`timescale 1ns/1ps
module adc_evt_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_a,
    input  logic trig_b,
    output logic edge_o
);

    logic [SYNC_STAGES:0] shreg;
    logic                 merged;

    assign merged = trig_a | trig_b;

    // Reset to ones: a start input already high at reset release gives no edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], merged};
        end
    end

    assign edge_o = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

endmodule

// File: rtl/adc_evt_conv.sv
`timescale 1ns/1ps
module adc_evt_conv
    import adc_evt_pkg::*;
#(
    parameter int LATENCY = 26,
    parameter int SETTLE  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_edge,
    output logic conv_busy
);

    localparam int MAXC  = (LATENCY > SETTLE) ? LATENCY : SETTLE;
    localparam int CNT_W = $clog2(MAXC + 1);

    conv_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pending_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CIDLE:   if (start_edge) state_d = CCONV;
            CCONV:   if (cnt_zero) state_d = CSETTLE;
            CSETTLE: if (cnt_zero) state_d = (pending_q || start_edge) ? CCONV : CIDLE;
            default: state_d = CIDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CIDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            pending_q <= 1'b0;
        end else begin
            unique case (state_q)
                CIDLE: begin
                    pending_q <= 1'b0;
                    if (start_edge) cnt_q <= CNT_W'(LATENCY - 1);
                end
                CCONV: begin
                    pending_q <= 1'b0;
                    if (cnt_zero) cnt_q <= CNT_W'(SETTLE - 1);
                    else          cnt_q <= cnt_q - 1'b1;
                end
                CSETTLE: begin
                    if (cnt_zero) begin
                        cnt_q     <= CNT_W'(LATENCY - 1);
                        pending_q <= 1'b0;
                    end else begin
                        cnt_q     <= cnt_q - 1'b1;
                        pending_q <= pending_q | start_edge;
                    end
                end
                default: begin
                    cnt_q     <= '0;
                    pending_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        conv_busy = (state_q == CCONV);
    end

endmodule

// File: rtl/adc_evt_handoff.sv
`timescale 1ns/1ps
module adc_evt_handoff
    import adc_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EOC_DELAY   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_busy,
    output logic busy_o,
    output logic eoc_o,
    output logic fire_o
);

    localparam int DW = $clog2(EOC_DELAY + 1);

    logic [SYNC_STAGES-1:0] bsync;
    hand_state_t            state_q, state_d;
    logic [DW-1:0]          dcnt_q;
    logic                   busy_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            bsync <= '0;
        end else begin
            bsync <= {bsync[SYNC_STAGES-2:0], conv_busy};
        end
    end

    assign busy_o    = bsync[SYNC_STAGES-1];
    assign busy_fall = bsync[SYNC_STAGES-1] & ~bsync[SYNC_STAGES-2];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIDLE:   if (busy_fall) state_d = HWAIT;
            HWAIT:   if (dcnt_q == '0) state_d = HIDLE;
            default: state_d = HIDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HIDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt_q <= '0;
        end else if (state_q == HIDLE && busy_fall) begin
            dcnt_q <= DW'(EOC_DELAY - 1);
        end else if (state_q == HWAIT && dcnt_q != '0) begin
            dcnt_q <= dcnt_q - 1'b1;
        end
    end

    assign fire_o = (state_q == HWAIT) && (dcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_o <= 1'b0;
        end else begin
            eoc_o <= fire_o;
        end
    end

endmodule

// File: rtl/adc_evt_seq.sv
`timescale 1ns/1ps
module adc_evt_seq
    import adc_evt_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic [1:0]        avg_sel,
    input  logic              fire,
    output logic [CH_W-1:0]   chan_o,
    output logic              eos_o
);

    logic [NUM_CH-1:0] meff;
    logic [CH_W-1:0]   chan_q, next_ch, last_ch;
    logic [PASS_W-1:0] pass_q, passes;
    logic              at_last, final_pass, found;

    assign meff   = (ch_mask == '0) ? NUM_CH'(1) : ch_mask;
    assign passes = avg_passes(avg_sel);

    always_comb begin
        next_ch = chan_q;
        found   = 1'b0;
        for (int i = 1; i <= NUM_CH; i++) begin
            int j;
            j = (int'(chan_q) + i) % NUM_CH;
            if (!found && meff[j]) begin
                next_ch = CH_W'(j);
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        last_ch = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (meff[i]) last_ch = CH_W'(i);
        end
    end

    assign at_last    = (chan_q == last_ch);
    assign final_pass = (pass_q >= passes - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            pass_q <= '0;
            eos_o  <= 1'b0;
        end else begin
            eos_o <= fire && at_last && final_pass;
            if (fire) begin
                chan_q <= next_ch;
                if (at_last) begin
                    if (final_pass) pass_q <= '0;
                    else            pass_q <= pass_q + 1'b1;
                end
            end
        end
    end

    assign chan_o = chan_q;

endmodule

// File: rtl/adc_evt_ctrl.sv
`timescale 1ns/1ps
module adc_evt_ctrl #(
    parameter int NUM_CH      = 16,
    parameter int LATENCY     = 26,
    parameter int SETTLE      = 4,
    parameter int EOC_DELAY   = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CH_W        = $clog2(NUM_CH)
) (
    input  logic              conv_clk,
    input  logic              if_clk,
    input  logic              rst,
    input  logic              trig_a,
    input  logic              trig_b,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic [1:0]        avg_sel,
    output logic              busy,
    output logic              eoc,
    output logic              eos,
    output logic [CH_W-1:0]   chan
);

    logic start_edge;
    logic conv_busy;
    logic fire;

    adc_evt_trig #(.SYNC_STAGES(SYNC_STAGES)) i_trig (
        .clk    (conv_clk),
        .rst    (rst),
        .trig_a (trig_a),
        .trig_b (trig_b),
        .edge_o (start_edge)
    );

    adc_evt_conv #(.LATENCY(LATENCY), .SETTLE(SETTLE)) i_conv (
        .clk        (conv_clk),
        .rst        (rst),
        .start_edge (start_edge),
        .conv_busy  (conv_busy)
    );

    adc_evt_handoff #(.SYNC_STAGES(SYNC_STAGES), .EOC_DELAY(EOC_DELAY)) i_hand (
        .clk       (if_clk),
        .rst       (rst),
        .conv_busy (conv_busy),
        .busy_o    (busy),
        .eoc_o     (eoc),
        .fire_o    (fire)
    );

    adc_evt_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_seq (
        .clk     (if_clk),
        .rst     (rst),
        .ch_mask (ch_mask),
        .avg_sel (avg_sel),
        .fire    (fire),
        .chan_o  (chan),
        .eos_o   (eos)
    );

endmodule

// File: rtl/adc_evt_ctrl_chk.sv
`timescale 1ns/1ps
module adc_evt_ctrl_chk #(
    parameter int CH_W = 4
) (
    input logic            conv_clk,
    input logic            if_clk,
    input logic            rst,
    input logic            conv_busy,
    input logic            eoc,
    input logic            eos,
    input logic [CH_W-1:0] chan
);

    p_eoc_one_cycle_r5: assert property (@(posedge if_clk) disable iff (rst)
        eoc |=> !eoc);

    p_eos_with_eoc_r7: assert property (@(posedge if_clk) disable iff (rst)
        eos |-> eoc);

    p_chan_moves_on_eoc_r6: assert property (@(posedge if_clk) disable iff (rst)
        !$stable(chan) |-> eoc);

    p_conv_not_cut_r3: assert property (@(posedge conv_clk) disable iff (rst)
        $rose(conv_busy) |=> conv_busy);

    p_gap_after_conv_r4: assert property (@(posedge conv_clk) disable iff (rst)
        $fell(conv_busy) |=> !conv_busy);

endmodule

bind adc_evt_ctrl adc_evt_ctrl_chk #(.CH_W(CH_W)) i_chk (.*);

// File: tb/test_adc_evt_ctrl.sv
`timescale 1ns/1ps
module test_adc_evt_ctrl;

    localparam int LAT = 26;
    localparam int VW  = 28;
    // {mask, avg_sel, use_b, conversions}
    localparam logic [VW-1:0] VEC [6] = '{
        {16'h0001, 2'b00, 1'b0, 9'd3},
        {16'h0015, 2'b00, 1'b1, 9'd6},
        {16'h8001, 2'b01, 1'b0, 9'd32},
        {16'h0001, 2'b10, 1'b1, 9'd64},
        {16'h0001, 2'b11, 1'b0, 9'd256},
        {16'h0000, 2'b00, 1'b0, 9'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_a = 1'b0, trig_b = 1'b0;
    logic [15:0] ch_mask = 16'h0001;
    logic [1:0]  avg_sel = 2'b00;
    logic        busy, eoc, eos;
    logic [3:0]  chan;

    int nchecks = 0, nfail = 0;
    int rise_k, fall_k, rise2_k, eoc_k, eoc_cnt, eos_cnt, eos_at;

    always #5 clk = ~clk;

    adc_evt_ctrl i_adc_evt_ctrl (
        .conv_clk(clk), .if_clk(clk), .rst(rst),
        .trig_a(trig_a), .trig_b(trig_b),
        .ch_mask(ch_mask), .avg_sel(avg_sel),
        .busy(busy), .eoc(eoc), .eos(eos), .chan(chan)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_exp(input int cur, input logic [15:0] m);
        logic [15:0] me;
        me = (m == 16'h0) ? 16'h0001 : m;
        for (int i = 1; i <= 16; i++) begin
            if (me[(cur + i) % 16]) return (cur + i) % 16;
        end
        return cur;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_a = 1'b0; trig_b = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_trig(input bit use_b, input logic v);
        if (use_b) trig_b = v; else trig_a = v;
    endtask

    // Called at a negedge; start input rises before the next edge E0.
    task automatic run_conv(input bit use_b, input int raise2, input int window);
        logic seen_fall;
        seen_fall = 1'b0;
        rise_k = -1; fall_k = -1; rise2_k = -1; eoc_k = -1;
        eoc_cnt = 0; eos_cnt = 0; eos_at = 0;
        set_trig(use_b, 1'b1);
        for (int k = 0; k < window; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (busy && rise_k < 0) rise_k = k;
            if (!busy && rise_k >= 0 && !seen_fall) begin fall_k = k; seen_fall = 1'b1; end
            if (busy && seen_fall && rise2_k < 0) rise2_k = k;
            if (eoc) begin
                eoc_cnt++;
                if (eoc_k < 0) begin eoc_k = k; eos_at = eos; end
            end
            if (eos) eos_cnt++;
            if (k == 2) set_trig(use_b, 1'b0);
            if (raise2 > 0 && k == raise2 - 1) set_trig(use_b, 1'b1);
            if (raise2 > 0 && k == raise2 + 2) set_trig(use_b, 1'b0);
        end
    endtask

    initial begin
        #1500000;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        do_reset();
        // R8 reset state
        chk("R8 busy after reset", busy, 0);
        chk("R8 eoc after reset", eoc, 0);
        chk("R8 eos after reset", eos, 0);
        chk("R8 chan after reset", chan, 0);

        // Vector walk: R1 R2 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            logic [15:0] m;
            int n, per, ch, eos_total, passes;
            m = VEC[v][27:12];
            do_reset();
            ch_mask = m;
            avg_sel = VEC[v][11:10];
            n = int'(VEC[v][8:0]);
            passes = (VEC[v][11:10] == 2'b00) ? 1 : (VEC[v][11:10] == 2'b01) ? 16 :
                     (VEC[v][11:10] == 2'b10) ? 64 : 256;
            per = $countones((m == 16'h0) ? 16'h0001 : m) * passes;
            ch = 0;
            eos_total = 0;
            for (int c = 1; c <= n; c++) begin
                chk("R6 chan before conversion", chan, ch);
                run_conv(VEC[v][9], -1, 50);
                chk("R2 busy rise edge", rise_k, 4);
                chk("R2 busy fall edge", fall_k, 4 + LAT);
                chk("R5 eoc edge", eoc_k, 4 + LAT + 16);
                chk("R1 one eoc per edge", eoc_cnt, 1);
                chk("R7 eos at this conversion", eos_at, (c % per == 0) ? 1 : 0);
                eos_total += eos_cnt;
                ch = next_exp(ch, m);
            end
            chk("R6 chan after wrap", chan, ch);
            chk("R7 eos total", eos_total, n / per);
        end

        // R3: second edge during conversion is ignored
        do_reset();
        ch_mask = 16'h0001; avg_sel = 2'b00;
        run_conv(1'b0, 10, 100);
        chk("R3 no second busy", rise2_k, -1);
        chk("R3 single eoc", eoc_cnt, 1);

        // R4: edge inside settling gap is held
        do_reset();
        run_conv(1'b1, 28, 100);
        chk("R4 first busy fall", fall_k, 4 + LAT);
        chk("R4 held conversion busy rise", rise2_k, 34);
        chk("R4 two eoc strobes", eoc_cnt, 2);

        // R8: start input held high across reset release
        @(negedge clk);
        rst = 1'b1; trig_a = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (busy) hi++;
            end
            chk("R8 no conversion from held start", hi, 0);
        end
        // R1: trig_b rising while trig_a high is no edge of the OR
        run_conv(1'b1, -1, 50);
        chk("R1 no conversion while other input high", rise_k, -1);
        trig_a = 1'b0;
        repeat (4) @(negedge clk);
        run_conv(1'b0, -1, 50);
        chk("R1 conversion after inputs drop", rise_k, 4);

        // R8 R6: reset mid-sequence returns chan to 0
        do_reset();
        ch_mask = 16'h0015;
        run_conv(1'b0, -1, 50);
        chk("R6 chan advanced", chan, 2);
        do_reset();
        chk("R8 chan cleared mid-sequence", chan, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule